// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead-Time Insertion

This block produces the four gate commands of one H-bridge: a high-side and a low-side switch on each of two legs, A and B. Each cycle it reads a bridge state (drive, fast decay, slow decay or coast), a polarity bit that picks which leg sources current, an active-low synchronous-rectification enable, a zero-current flag from the current sense path and two disable inputs. From these it derives the gate pattern the bridge should have. A per-leg sequencer then makes sure that no switch turns on until its partner on the same leg has been off for a programmable number of master-clock cycles.

During decay the block can switch on the transistor that carries the recirculating current (synchronous rectification). This cuts conduction loss compared with a body diode. The rectifying switches are dropped when the zero-current flag rises, so the winding current cannot reverse. An output-disable input and a fault input each force every gate off at the next clock edge. Turn-off is never delayed. Only turn-on waits for the dead interval.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While `rst_n` is low all four gate outputs are 0.
- R2: On either leg the high-side and low-side gates are never both 1 in the same cycle, for any input sequence.
- R3: A gate that was off turns on only after both gates of its leg have been 0 for at least `DEAD_CYC` (default 3) consecutive clock cycles. A leg counts as rested when it comes out of reset. A gate that is no longer wanted turns off at the next clock edge.
- R4: `decay_mode` encoding: 2'b00 drive, 2'b01 fast decay, 2'b10 slow decay, 2'b11 coast. In drive with `polarity`=0, `gh_a` and `gl_b` are on. With `polarity`=1, `gh_b` and `gl_a` are on. A change that needs no dead wait appears one clock edge after the input changes.
- R5: In slow decay the source-side high gate is off and the sink-leg low gate stays on. The source leg is A when `polarity`=0 and B when `polarity`=1. With `sr_n`=0 and `zero_i`=0 the source-leg low gate is also on, so both low gates conduct.
- R6: In fast decay both gates of the driving diagonal are off. With `sr_n`=0 and `zero_i`=0 the opposite diagonal is on: `gh_b`/`gl_a` for `polarity`=0, and `gh_a`/`gl_b` for `polarity`=1.
- R7: With `sr_n`=1, or with `zero_i`=1, no rectifying gate is on during decay. Slow decay keeps only the sink-leg low gate, and fast decay turns all gates off. So at most one gate is on from the next edge.
- R8: In coast (2'b11) all gates are off from the next edge.
- R9: While `out_dis`=1 or `fault`=1 all gates are off from the next edge. After release, the pattern resumes subject to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; dead time is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| decay_mode | input | 2 | Bridge state: 00 drive, 01 fast decay, 10 slow decay, 11 coast |
| polarity | input | 1 | 0: leg A sources current, 1: leg B sources current |
| sr_n | input | 1 | Synchronous rectification enable, active low |
| zero_i | input | 1 | Winding current has reached zero |
| out_dis | input | 1 | High forces all gates off |
| fault | input | 1 | High forces all gates off |
| gh_a | output | 1 | Leg A high-side gate |
| gl_a | output | 1 | Leg A low-side gate |
| gh_b | output | 1 | Leg B high-side gate |
| gl_b | output | 1 | Leg B low-side gate |

## Verification
The per-leg rest counter and gate registers are the only state. A wrong value shows at the gate outputs within one dead interval. A counter that is too high lets a gate rise early after its partner falls, which the bench sees in the first cycle of a polarity swap or a drive-to-decay change. A counter that is stuck or too low holds a gate off past the third idle cycle, which the bench sees one cycle after the expected turn-on. A wrong decode of mode, polarity or the rectification inputs shows one edge after the input change as a gate pattern that differs from the reference model.

// File: rtl/hgs_pkg.sv
package hgs_pkg;

  typedef enum logic [1:0] {
    HB_DRIVE = 2'b00,
    HB_FAST  = 2'b01,
    HB_SLOW  = 2'b10,
    HB_COAST = 2'b11
  } hb_mode_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_gate_t;

  localparam int NUM_LEGS = 2;

endpackage

// File: rtl/hgs_pattern.sv
// Target gate pattern for both legs, before dead-time sequencing.
module hgs_pattern
  import hgs_pkg::*;
(
  input  logic                      [1:0] mode,
  input  logic                            polarity,
  input  logic                            sr_n,
  input  logic                            zero_i,
  input  logic                            out_dis,
  input  logic                            fault,
  output leg_gate_t [NUM_LEGS-1:0]        want
);

  logic en;
  logic rect_on;

  assign en      = ~out_dis & ~fault;
  assign rect_on = ~sr_n & ~zero_i;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    logic src;
    assign src = (polarity == 1'(g));

    always_comb begin
      want[g] = '0;
      unique case (hb_mode_e'(mode))
        HB_DRIVE: begin
          want[g].hi = src;
          want[g].lo = ~src;
        end
        HB_FAST: begin
          want[g].hi = ~src & rect_on;
          want[g].lo = src & rect_on;
        end
        HB_SLOW: begin
          want[g].hi = 1'b0;
          want[g].lo = ~src | rect_on;
        end
        default: want[g] = '0;
      endcase
      if (!en) want[g] = '0;
    end
  end

endmodule

// File: rtl/hgs_leg.sv
// One half-bridge: immediate turn-off, turn-on only after a rest interval.
module hgs_leg
  import hgs_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  leg_gate_t want,
  output leg_gate_t gate
);

  localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] REST_MAX = CW'(DEAD_CYC);

  leg_gate_t     gate_q, gate_d;
  logic [CW-1:0] rest_q, rest_d;
  logic          rested;
  logic          rest_en;

  always_comb begin
    rested    = (rest_q >= REST_MAX);
    gate_d.hi = want.hi & ~want.lo & (gate_q.hi | (~gate_q.lo & rested));
    gate_d.lo = want.lo & ~want.hi & (gate_q.lo | (~gate_q.hi & rested));
    if (gate_d.hi | gate_d.lo) begin
      rest_d  = '0;
      rest_en = (rest_q != '0);
    end else begin
      rest_d  = CW'(rest_q + 1'b1);
      rest_en = ~rested;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
    end else begin
      gate_q <= gate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rest_q <= REST_MAX;
    end else if (rest_en) begin
      rest_q <= rest_d;
    end
  end

  assign gate = gate_q;

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hgs_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] decay_mode,
  input  logic       polarity,
  input  logic       sr_n,
  input  logic       zero_i,
  input  logic       out_dis,
  input  logic       fault,
  output logic       gh_a,
  output logic       gl_a,
  output logic       gh_b,
  output logic       gl_b
);

  leg_gate_t [NUM_LEGS-1:0] want;
  leg_gate_t [NUM_LEGS-1:0] gate;

  hgs_pattern u_pattern (
    .mode     (decay_mode),
    .polarity (polarity),
    .sr_n     (sr_n),
    .zero_i   (zero_i),
    .out_dis  (out_dis),
    .fault    (fault),
    .want     (want)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hgs_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want[g]),
      .gate  (gate[g])
    );
  end

  assign gh_a = gate[0].hi;
  assign gl_a = gate[0].lo;
  assign gh_b = gate[1].hi;
  assign gl_b = gate[1].lo;

endmodule

// File: rtl/hbridge_gate_seq_chk.sv
module hbridge_gate_seq_chk #(
  parameter int DEAD_CYC = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] decay_mode,
  input logic       sr_n,
  input logic       zero_i,
  input logic       out_dis,
  input logic       fault,
  input logic       gh_a,
  input logic       gl_a,
  input logic       gh_b,
  input logic       gl_b
);

  // Consecutive cycles each gate has been low, saturating at DEAD_CYC.
  int off_gh_a, off_gl_a, off_gh_b, off_gl_b;

  function automatic int bump(input int v, input logic on);
    if (on) return 0;
    return (v >= DEAD_CYC) ? DEAD_CYC : v + 1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_gh_a <= DEAD_CYC;
      off_gl_a <= DEAD_CYC;
      off_gh_b <= DEAD_CYC;
      off_gl_b <= DEAD_CYC;
    end else begin
      off_gh_a <= bump(off_gh_a, gh_a);
      off_gl_a <= bump(off_gl_a, gl_a);
      off_gh_b <= bump(off_gh_b, gh_b);
      off_gl_b <= bump(off_gl_b, gl_b);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_off: assert ({gh_a, gl_a, gh_b, gl_b} == 4'b0000)
        else $error("a_r1_reset_off");
    end
  end

  a_r2_leg_a_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(gh_a && gl_a));
  a_r2_leg_b_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(gh_b && gl_b));

  a_r3_dead_gh_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gh_a) |-> (off_gl_a >= DEAD_CYC));
  a_r3_dead_gl_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl_a) |-> (off_gh_a >= DEAD_CYC));
  a_r3_dead_gh_b: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gh_b) |-> (off_gl_b >= DEAD_CYC));
  a_r3_dead_gl_b: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl_b) |-> (off_gh_b >= DEAD_CYC));

  a_r7_no_rectify: assert property (@(posedge clk) disable iff (!rst_n)
    ((decay_mode != 2'b00) && (sr_n || zero_i))
      |=> ($countones({gh_a, gl_a, gh_b, gl_b}) <= 1));

  a_r8_coast_off: assert property (@(posedge clk) disable iff (!rst_n)
    (decay_mode == 2'b11) |=> ({gh_a, gl_a, gh_b, gl_b} == 4'b0000));

  a_r9_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dis || fault) |=> ({gh_a, gl_a, gh_b, gl_b} == 4'b0000));

endmodule

bind hbridge_gate_seq hbridge_gate_seq_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .decay_mode (decay_mode),
  .sr_n       (sr_n),
  .zero_i     (zero_i),
  .out_dis    (out_dis),
  .fault      (fault),
  .gh_a       (gh_a),
  .gl_a       (gl_a),
  .gh_b       (gh_b),
  .gl_b       (gl_b)
);

// File: tb/hbridge_gate_seq_bench.sv
module hbridge_gate_seq_bench;

  localparam time CLK_PERIOD = 10;
  localparam int  DEAD       = 3;

  logic       clk;
  logic       rst_n;
  logic [1:0] decay_mode;
  logic       polarity, sr_n, zero_i, out_dis, fault;
  logic       gh_a, gl_a, gh_b, gl_b;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  hbridge_gate_seq #(.DEAD_CYC(DEAD)) u_hbridge_gate_seq (
    .clk(clk), .rst_n(rst_n), .decay_mode(decay_mode), .polarity(polarity),
    .sr_n(sr_n), .zero_i(zero_i), .out_dis(out_dis), .fault(fault),
    .gh_a(gh_a), .gl_a(gl_a), .gh_b(gh_b), .gl_b(gl_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference: index 0 = leg A, 1 = leg B.
  int m_hi[2];
  int m_lo[2];
  int m_rest[2];

  function automatic void target(input int leg, output int h, output int l);
    bit src, rect;
    src  = (polarity == leg[0]);
    rect = !sr_n && !zero_i;
    h = 0; l = 0;
    if (out_dis || fault) return;
    case (decay_mode)
      2'b00: begin h = src; l = !src; end
      2'b01: begin h = !src && rect; l = src && rect; end
      2'b10: begin h = 0; l = !src || rect; end
      default: begin h = 0; l = 0; end
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_hi[i] = 0; m_lo[i] = 0; m_rest[i] = DEAD;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        int h, l, nh, nl;
        target(i, h, l);
        nh = (h && (m_hi[i] || (!m_lo[i] && m_rest[i] >= DEAD))) ? 1 : 0;
        nl = (l && (m_lo[i] || (!m_hi[i] && m_rest[i] >= DEAD))) ? 1 : 0;
        m_hi[i] = nh;
        m_lo[i] = nl;
        if (nh || nl) m_rest[i] = 0;
        else if (m_rest[i] < DEAD) m_rest[i] = m_rest[i] + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] exp_g;
      exp_g = {m_hi[0] != 0, m_lo[0] != 0, m_hi[1] != 0, m_lo[1] != 0};
      checks++;
      if ({gh_a, gl_a, gh_b, gl_b} !== exp_g) begin
        errors++;
        $display("FAIL model R3 R4 R5 R6 R7 R8 R9 t=%0t actual=%b expected=%b",
                 $time, {gh_a, gl_a, gh_b, gl_b}, exp_g);
      end
      checks++;
      if ((gh_a && gl_a) || (gh_b && gl_b)) begin
        errors++;
        $display("FAIL R2 leg overlap actual=%b expected=no overlap",
                 {gh_a, gl_a, gh_b, gl_b});
      end
    end
  end

  // Outputs in order {gh_a, gl_a, gh_b, gl_b}
  task automatic expect4(input string req, input logic [3:0] exp_g);
    checks++;
    if ({gh_a, gl_a, gh_b, gl_b} !== exp_g) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time,
               {gh_a, gl_a, gh_b, gl_b}, exp_g);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic apply(input logic [1:0] m, input logic p, input logic s,
                       input logic z, input logic d, input logic f);
    decay_mode = m; polarity = p; sr_n = s; zero_i = z; out_dis = d; fault = f;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(3);
    expect4("R1 reset", 4'b0000);
    rst_n = 1'b1;
    tick();
    expect4("R3 R4 rested after reset, drive pol0", 4'b1001);
    tick(4);
    expect4("R4 drive pol0", 4'b1001);

    // Polarity swap: both legs wait DEAD cycles.
    polarity = 1'b1;
    tick(); expect4("R3 swap edge1", 4'b0000);
    tick(); expect4("R3 swap edge2", 4'b0000);
    tick(); expect4("R3 swap edge3", 4'b0000);
    tick(); expect4("R3 R4 swap on, drive pol1", 4'b0110);

    // Fast decay with rectification, polarity 1.
    apply(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(6); expect4("R6 fast rect pol1", 4'b1001);
    sr_n = 1'b1;
    tick(); expect4("R7 fast sr disabled", 4'b0000);
    sr_n = 1'b0;
    tick(6); expect4("R6 fast rect restored", 4'b1001);
    zero_i = 1'b1;
    tick(); expect4("R7 fast zero current", 4'b0000);

    // Drive pol0 then slow decay with rectification, edge by edge.
    apply(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(6); expect4("R4 drive pol0 again", 4'b1001);
    decay_mode = 2'b10;
    tick(); expect4("R5 slow edge1", 4'b0001);
    tick(); expect4("R3 slow edge2", 4'b0001);
    tick(); expect4("R3 slow edge3", 4'b0001);
    tick(); expect4("R3 R5 slow both lows", 4'b0101);
    zero_i = 1'b1;
    tick(); expect4("R7 slow zero current", 4'b0001);
    apply(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    tick(); expect4("R7 slow sr disabled pol0", 4'b0001);
    polarity = 1'b1;
    tick(6); expect4("R5 slow sink low pol1", 4'b0100);
    sr_n = 1'b0;
    tick(6); expect4("R5 slow both lows pol1", 4'b0101);
    decay_mode = 2'b11;
    tick(); expect4("R8 coast", 4'b0000);

    // Disable and fault.
    apply(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(6); expect4("R4 drive pol0 before disable", 4'b1001);
    out_dis = 1'b1;
    tick(); expect4("R9 out_dis", 4'b0000);
    tick(4); expect4("R9 out_dis held", 4'b0000);
    out_dis = 1'b0;
    tick(); expect4("R9 release rested", 4'b1001);
    fault = 1'b1;
    tick(); expect4("R9 fault", 4'b0000);
    fault = 1'b0;
    tick(6); expect4("R9 fault release", 4'b1001);

    // Random phase, checked every cycle against the reference model.
    for (int k = 0; k < 1500; k++) begin
      apply(2'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
            ($urandom % 10) == 0, ($urandom % 16) == 0);
      tick(1 + ($urandom % 7));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule